// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address. It holds four 16-bit segment registers: code, data, stack and extra. For each request it picks one of them, shifts that segment value left by four bits and adds the offset. The sum wraps inside the 20-bit address space. The offset is whatever the address path supplies: an instruction pointer, a base or index register, or a displacement sum. The request also says which kind of register produced the offset, and the block uses that to choose the default segment.

A data access can carry a segment override, which replaces the default segment. Instruction fetch never takes the override, and neither do string destination operands. A request that tries to form an address from a byte half of the base register is reported as invalid. Segment registers are loaded through a single write port. The result is registered and appears one clock after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: For a valid request, `addr_phys` equals (selected segment × 16 + offset) modulo 2^20. It is presented with `addr_valid`=1 on the cycle after the request is sampled. For example, segment 16'h1230 with offset 16'h0045 gives 20'h12345, and segment 16'hFFFF with offset 16'hFFFF gives 20'h0FFEF.
- R2: Source code 0 (instruction fetch) always selects the code segment. `addr_seg` reports 0 even when `ovr_en` is high.
- R3: Source codes 1 (base register), 2 (source index) and 3 (destination index, non-string) select the data segment when `ovr_en` is low. `addr_seg` reports 1.
- R4: Source codes 4 (base pointer) and 5 (stack pointer) select the stack segment when `ovr_en` is low. `addr_seg` reports 2.
- R5: Source code 6 (string destination index) always selects the extra segment. `addr_seg` reports 3 even when `ovr_en` is high.
- R6: For source codes 1 to 5 with `ovr_en` high, the segment named by `ovr_sel` is used and reported. The segment ids are 0 code, 1 data, 2 stack and 3 extra.
- R7: Source code 7 (byte half of the base register) gives `addr_valid`=1 with `addr_bad`=1, `addr_phys`=0 and `addr_seg`=0.
- R8: A write with `seg_wr_en`=1 loads `seg_wr_data` into the segment named by `seg_wr_sel`. A request sampled on the same edge still uses the old value. Requests sampled from the next edge onward use the new value.
- R9: While `rst_n` is low, all outputs are 0 and all four segment registers are cleared to 0.
- R10: The cycle after an edge where `req_valid` is low, `addr_valid`, `addr_bad`, `addr_seg` and `addr_phys` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment id to write |
| seg_wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Address request present |
| req_src | input | 3 | Kind of register that produced the offset |
| req_offset | input | 16 | Offset value |
| ovr_en | input | 1 | Segment override active |
| ovr_sel | input | 2 | Override segment id |
| addr_valid | output | 1 | Result present |
| addr_bad | output | 1 | Request could not form an address |
| addr_seg | output | 2 | Segment id used |
| addr_phys | output | 20 | Physical address |

## Verification
Each address result is due exactly one clock after the edge that samples its request. A segment write becomes visible to requests sampled one edge after the write. The bench drives inputs on the falling edge and updates its reference model at the rising edge. The model computes the expected output from the segment values it held before that edge, then applies any write. The outputs are compared at the following falling edge, so every comparison lands on the cycle in which the registered result is due.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [2:0] {
        SRC_FETCH    = 3'd0,
        SRC_BASE     = 3'd1,
        SRC_SIDX     = 3'd2,
        SRC_DIDX     = 3'd3,
        SRC_BPTR     = 3'd4,
        SRC_SPTR     = 3'd5,
        SRC_STRDST   = 3'd6,
        SRC_BYTEHALF = 3'd7
    } src_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int SEG_W   = 16,
    parameter int NUM_SEG = 4,
    localparam int SEL_W  = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_data
);
    logic [NUM_SEG-1:0][SEG_W-1:0] regs_d, regs_q;

    always_comb begin
        for (int i = 0; i < NUM_SEG; i++) begin
            if (wr_en && (wr_sel == SEL_W'(i)))
                regs_d[i] = wr_data;
            else
                regs_d[i] = regs_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    assign rd_data = regs_q[rd_sel];
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_pkg::*;
(
    input  src_e    src,
    input  logic    ovr_en,
    input  seg_id_e ovr_sel,
    output seg_id_e seg_id,
    output logic    bad
);
    always_comb begin
        seg_id = SEG_CODE;
        bad    = 1'b0;
        unique case (src)
            SRC_FETCH:                     seg_id = SEG_CODE;
            SRC_STRDST:                    seg_id = SEG_EXTRA;
            SRC_BASE, SRC_SIDX, SRC_DIDX:  seg_id = ovr_en ? ovr_sel : SEG_DATA;
            SRC_BPTR, SRC_SPTR:            seg_id = ovr_en ? ovr_sel : SEG_STACK;
            SRC_BYTEHALF:                  bad    = 1'b1;
            default:                       bad    = 1'b1;
        endcase
    end
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    localparam int PA_W  = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] base_w;
    logic [PA_W-1:0] off_w;

    assign base_w = {seg, {SHIFT{1'b0}}};
    assign off_w  = PA_W'(off);
    assign phys   = base_w + off_w;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [1:0]       seg_wr_sel,
    input  logic [SEG_W-1:0] seg_wr_data,
    input  logic             req_valid,
    input  logic [2:0]       req_src,
    input  logic [OFF_W-1:0] req_offset,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_sel,
    output logic             addr_valid,
    output logic             addr_bad,
    output logic [1:0]       addr_seg,
    output logic [PA_W-1:0]  addr_phys
);
    typedef struct packed {
        logic            valid;
        logic            bad;
        seg_id_e         seg;
        logic [PA_W-1:0] phys;
    } out_t;

    out_t out_d, out_q;

    seg_id_e         sel_id;
    logic            sel_bad;
    logic [SEG_W-1:0] seg_val;
    logic [PA_W-1:0]  sum;

    seg_select u_sel (
        .src    (src_e'(req_src)),
        .ovr_en (ovr_en),
        .ovr_sel(seg_id_e'(ovr_sel)),
        .seg_id (sel_id),
        .bad    (sel_bad)
    );

    seg_regfile #(.SEG_W(SEG_W), .NUM_SEG(4)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (seg_wr_en),
        .wr_sel (seg_wr_sel),
        .wr_data(seg_wr_data),
        .rd_sel (sel_id),
        .rd_data(seg_val)
    );

    addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .seg (seg_val),
        .off (req_offset),
        .phys(sum)
    );

    always_comb begin
        out_d = '0;
        if (req_valid) begin
            out_d.valid = 1'b1;
            if (sel_bad) begin
                out_d.bad = 1'b1;
            end else begin
                out_d.seg  = sel_id;
                out_d.phys = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign addr_valid = out_q.valid;
    assign addr_bad   = out_q.bad;
    assign addr_seg   = out_q.seg;
    assign addr_phys  = out_q.phys;
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_src,
    input logic [OFF_W-1:0] req_offset,
    input logic             ovr_en,
    input logic             addr_valid,
    input logic             addr_bad,
    input logic [1:0]       addr_seg,
    input logic [PA_W-1:0]  addr_phys
);
    assert_low_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_bad) |-> addr_phys[SHIFT-1:0] == $past(req_offset[SHIFT-1:0]));

    assert_fetch_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 3'd0) |=> (addr_seg == 2'd0 && !addr_bad));

    assert_data_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovr_en && req_src >= 3'd1 && req_src <= 3'd3) |=> addr_seg == 2'd1);

    assert_stack_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovr_en && (req_src == 3'd4 || req_src == 3'd5)) |=> addr_seg == 2'd2);

    assert_strdst_extra_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 3'd6) |=> addr_seg == 2'd3);

    assert_bad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_bad |-> (addr_valid && addr_phys == '0 && addr_seg == 2'd0));

    assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && !addr_bad && addr_phys == '0));
endmodule

bind seg_addr_gen seg_addr_chk #(.OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_offset(req_offset),
    .ovr_en    (ovr_en),
    .addr_valid(addr_valid),
    .addr_bad  (addr_bad),
    .addr_seg  (addr_seg),
    .addr_phys (addr_phys)
);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_src = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        addr_valid, addr_bad;
    logic [1:0]  addr_seg;
    logic [19:0] addr_phys;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    int          m_seg [4];
    logic        e_valid, e_bad;
    logic [1:0]  e_seg;
    logic [19:0] e_phys;
    string       e_tag = "R9";
    bit          compare_on = 1'b0;

    always #2 clk = ~clk;

    seg_addr_gen u0 (.*);

    // reference model: evaluated on each rising edge from pre-edge state
    always @(posedge clk) begin
        int s;
        longint full;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_seg[i] = 0;
            e_valid = 0; e_bad = 0; e_seg = 0; e_phys = 0; e_tag = "R9";
        end else begin
            e_valid = 0; e_bad = 0; e_seg = 0; e_phys = 0; e_tag = "R10";
            if (req_valid) begin
                e_valid = 1;
                s = -1;
                case (req_src)
                    3'd0: begin s = 0; e_tag = "R2"; end
                    3'd6: begin s = 3; e_tag = "R5"; end
                    3'd7: begin e_bad = 1; e_tag = "R7"; end
                    3'd4, 3'd5: begin
                        s = ovr_en ? int'(ovr_sel) : 2;
                        e_tag = ovr_en ? "R6" : "R4";
                    end
                    default: begin
                        s = ovr_en ? int'(ovr_sel) : 1;
                        e_tag = ovr_en ? "R6" : "R3";
                    end
                endcase
                if (s >= 0) begin
                    full = longint'(m_seg[s]) * 16 + longint'(req_offset);
                    e_seg = 2'(s);
                    e_phys = 20'(full % 64'h100000);
                    if (full >= 64'h100000) e_tag = "R1";
                end
            end
            if (seg_wr_en) begin
                if (req_valid) e_tag = "R8";
                m_seg[seg_wr_sel] = int'(seg_wr_data);
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (compare_on) begin
            n_checks++;
            if (addr_valid !== e_valid || addr_bad !== e_bad ||
                addr_seg !== e_seg || addr_phys !== e_phys) begin
                n_fail++;
                $display("FAIL %s: got v=%0b b=%0b s=%0d pa=%05h exp v=%0b b=%0b s=%0d pa=%05h",
                         e_tag, addr_valid, addr_bad, addr_seg, addr_phys,
                         e_valid, e_bad, e_seg, e_phys);
            end
        end
    end

    task automatic check_now(string tag, logic [19:0] exp_pa, logic [1:0] exp_s);
        n_checks++;
        if (addr_phys !== exp_pa || addr_seg !== exp_s || addr_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL %s: got pa=%05h s=%0d exp pa=%05h s=%0d", tag, addr_phys, addr_seg, exp_pa, exp_s);
        end
    endtask

    task automatic step(bit we, int wsel, int wdata, bit rv, int src, int off, bit oe, int os);
        seg_wr_en = we; seg_wr_sel = 2'(wsel); seg_wr_data = 16'(wdata);
        req_valid = rv; req_src = 3'(src); req_offset = 16'(off);
        ovr_en = oe; ovr_sel = 2'(os);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        step(0,0,0, 1,1,16'h1234, 0,0);
        // R9: outputs held at zero in reset
        n_checks++;
        if (addr_valid !== 0 || addr_bad !== 0 || addr_seg !== 0 || addr_phys !== 0) begin
            n_fail++;
            $display("FAIL R9: got v=%0b pa=%05h exp v=0 pa=00000", addr_valid, addr_phys);
        end
        rst_n = 1'b1;
        step(0,0,0, 0,0,0, 0,0);
        compare_on = 1'b1;
        // R1 worked example
        step(1,1,16'h1230, 0,0,0, 0,0);
        step(0,0,0, 1,2,16'h0045, 0,0);
        check_now("R1", 20'h12345, 2'd1);
        step(1,2,16'hFFFF, 0,0,0, 0,0);
        step(0,0,0, 1,5,16'hFFFF, 0,0);
        check_now("R1", 20'h0FFEF, 2'd2);
        step(1,0,16'hF000, 0,0,0, 0,0);
        step(1,3,16'h2000, 0,0,0, 0,0);
        // R2 fetch ignores override
        step(0,0,0, 1,0,16'h0010, 1,3);
        check_now("R2", 20'hF0010, 2'd0);
        // R5 string destination ignores override
        step(0,0,0, 1,6,16'h0004, 1,1);
        check_now("R5", 20'h20004, 2'd3);
        // R6 override onto extra for a base pointer access
        step(0,0,0, 1,4,16'h0001, 1,3);
        check_now("R6", 20'h20001, 2'd3);
        // R8 same-edge write uses old value, then new
        step(1,1,16'h4000, 1,1,16'h0002, 0,0);
        check_now("R8", 20'h12302, 2'd1);
        step(0,0,0, 1,1,16'h0002, 0,0);
        check_now("R8", 20'h40002, 2'd1);
        // R7 byte-half request
        step(0,0,0, 1,7,16'h1111, 0,0);
        n_checks++;
        if (addr_bad !== 1'b1 || addr_phys !== 0) begin
            n_fail++;
            $display("FAIL R7: got bad=%0b pa=%05h exp bad=1 pa=00000", addr_bad, addr_phys);
        end
        // R3 and R4 across all default sources, R10 idle gaps
        for (int k = 1; k <= 5; k++) step(0,0,0, 1,k,k*16'h0101, 0,0);
        step(0,0,0, 0,3,16'hAAAA, 1,2);
        // randomized traffic
        for (int n = 0; n < 600; n++)
            step($urandom_range(0,3) == 0, $urandom_range(0,3), $urandom,
                 $urandom_range(0,4) != 0, $urandom_range(0,7), $urandom,
                 $urandom_range(0,1), $urandom_range(0,3));
        step(0,0,0, 0,0,0, 0,0);
        finish_run();
    end

    initial begin
        wait (cycles >= 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles exp completion", cycles);
        finish_run();
    end
endmodule